// File: doc/BRIEF.md
# Coprocessor Execute Stage with ALU and Flag Branching

This block is the execute stage of a small 16-bit coprocessor. It holds four 16-bit general registers and a pair of condition flags, decodes one 32-bit instruction word per cycle, and produces the register write-back and the address of the next instruction. Only the arithmetic class and the branch class are decoded; every other word passes through as a sequential step that changes no state.

The arithmetic class takes its second operand either from a register or from a 16-bit literal in the word, and updates a zero flag and an overflow flag on every valid operation. The branch class has two forms. The absolute form jumps to a literal or register-held word address, either always or on one of the stored flags. The relative form compares R0 against a literal and moves the program counter forward or backward by a 7-bit magnitude. Program counters are 11-bit word addresses and wrap modulo 2048.

The fetch stage drives `pc` and `insn` with `insn_valid`; write-back, `next_pc` and the flag outputs are combinational from the word and the current state. Registers and flags change at the rising edge that ends a valid cycle.

Top module: `cp_exec`

## Requirements
- R1: After reset all four registers read as 0 and both flags are 0.
- R2: An arithmetic word has bits [31:28]=7 and sub-class bits [27:25]=0 for register form: destination [1:0], operand A register [3:2], operand B register [5:4]; select [24:21] picks 0 add, 1 subtract, 2 AND, 3 OR, 5 shift left, 6 shift right, all modulo 2^16, shifts logical by the full 16-bit operand B (16 or more gives 0).
- R3: Sub-class 1 takes operand B from the literal in bits [19:4], with the same selects and destination as R2.
- R4: Select 4 (move) writes operand B, register or literal, to the destination.
- R5: Each written arithmetic result sets the zero flag to (result == 0).
- R6: The overflow flag is set by a carry out of bit 15 on add or a borrow (A < B unsigned) on subtract, and is cleared by every other written arithmetic operation.
- R7: Selects 7 to 15, sub-classes other than 0 and 1 in the arithmetic class, branches and all other major codes write no register and leave both flags unchanged.
- R8: Absolute branch (bits [31:28]=8, [27:25]=0): target is the register [1:0] low 11 bits when bit 21 is 1, else the literal in bits [12:2]; condition [24:22] is 0 always, 1 if zero flag, 2 if overflow flag, other codes never taken.
- R9: Relative branch (sub-class 1): bit 16 = 0 is taken when R0 < bits [15:0], bit 16 = 1 when R0 >= bits [15:0], unsigned; target is PC plus the magnitude [23:17], or minus it when bit 24 is 1, modulo 2048.
- R10: With `insn_valid` high and no branch taken, `next_pc` is PC + 1 modulo 2048.
- R11: With `insn_valid` low, no register or flag changes, `wb_en` is 0 and `next_pc` equals `pc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | Instruction word present this cycle |
| insn | input | 32 | Instruction word |
| pc | input | 11 | Word address of the instruction |
| next_pc | output | 11 | Word address of the following instruction |
| wb_en | output | 1 | Register write this cycle |
| wb_sel | output | 2 | Register written |
| wb_data | output | 16 | Value written |
| zero_flag | output | 1 | Stored zero flag |
| ovf_flag | output | 1 | Stored overflow flag |

## Verification
The assertions assume `insn`, `pc` and `insn_valid` are stable from one falling edge through the next rising edge and carry no unknown bits while reset is released; the bench changes them only at falling edges and always drives defined words. They also take `pc` as a free input, not one tied to `next_pc`, so the bench picks program counters near both ends of the address range to reach the wrap cases directly. Operand values are loaded through move-literal words so the register contents at every checked step are known to the bench.

// File: rtl/cp_exec.sv
module cp_exec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic [31:0] insn,
  input  logic [10:0] pc,
  output logic [10:0] next_pc,
  output logic        wb_en,
  output logic [1:0]  wb_sel,
  output logic [15:0] wb_data,
  output logic        zero_flag,
  output logic        ovf_flag
);

  localparam logic [3:0] MAJ_ALU = 4'd7;
  localparam logic [3:0] MAJ_BR  = 4'd8;

  logic [15:0] gpr [4];

  logic [3:0]  major;
  logic [2:0]  sub;
  logic [3:0]  sel;
  logic        is_alu, is_br;
  logic [15:0] op_a, op_b;
  logic [15:0] res;
  logic        res_ovf, sel_ok;

  assign major  = insn[31:28];
  assign sub    = insn[27:25];
  assign sel    = insn[24:21];
  assign is_alu = (major == MAJ_ALU) && (sub == 3'd0 || sub == 3'd1);
  assign is_br  = (major == MAJ_BR);
  assign op_a   = gpr[insn[3:2]];
  assign op_b   = (sub == 3'd1) ? insn[19:4] : gpr[insn[5:4]];

  always_comb begin
    res     = '0;
    res_ovf = 1'b0;
    sel_ok  = 1'b1;
    case (sel)
      4'd0: {res_ovf, res} = {1'b0, op_a} + {1'b0, op_b};
      4'd1: begin
        res     = op_a - op_b;
        res_ovf = op_a < op_b;
      end
      4'd2: res = op_a & op_b;
      4'd3: res = op_a | op_b;
      4'd4: res = op_b;
      4'd5: res = op_a << op_b;
      4'd6: res = op_a >> op_b;
      default: sel_ok = 1'b0;
    endcase
  end

  assign wb_en   = insn_valid && is_alu && sel_ok;
  assign wb_sel  = insn[1:0];
  assign wb_data = res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) gpr[i] <= '0;
      zero_flag <= 1'b0;
      ovf_flag  <= 1'b0;
    end else if (wb_en) begin
      gpr[wb_sel] <= res;
      zero_flag   <= (res == 16'd0);
      ovf_flag    <= res_ovf;
    end
  end

  logic [10:0] abs_tgt, rel_tgt, seq_pc;
  logic [6:0]  rel_mag;
  logic        abs_take, rel_take, take;

  assign seq_pc  = pc + 11'd1;
  assign abs_tgt = insn[21] ? gpr[insn[1:0]][10:0] : insn[12:2];
  assign rel_mag = insn[23:17];
  assign rel_tgt = insn[24] ? pc - {4'd0, rel_mag} : pc + {4'd0, rel_mag};

  always_comb begin
    case (insn[24:22])
      3'd0:    abs_take = 1'b1;
      3'd1:    abs_take = zero_flag;
      3'd2:    abs_take = ovf_flag;
      default: abs_take = 1'b0;
    endcase
  end

  assign rel_take = insn[16] ? (gpr[0] >= insn[15:0]) : (gpr[0] < insn[15:0]);
  assign take = is_br && ((sub == 3'd0 && abs_take) || (sub == 3'd1 && rel_take));

  always_comb begin
    if (!insn_valid)  next_pc = pc;
    else if (!take)   next_pc = seq_pc;
    else if (sub == 3'd0) next_pc = abs_tgt;
    else              next_pc = rel_tgt;
  end

endmodule

module cp_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_valid,
  input logic [31:0] insn,
  input logic [10:0] pc,
  input logic [10:0] next_pc,
  input logic        wb_en,
  input logic [15:0] wb_data,
  input logic        zero_flag,
  input logic        ovf_flag
);

  a_r7_branch_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[31:28] == 4'd8) |=> $stable({zero_flag, ovf_flag}));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |-> (!wb_en && next_pc == pc));

  a_r11_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> $stable({zero_flag, ovf_flag}));

  a_r5_zero_follows_result: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> (zero_flag == ($past(wb_data) == 16'd0)));

  a_r6_logic_clears_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && insn[24:21] >= 4'd2) |=> !ovf_flag);

  a_r10_sequential_step: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[31:28] != 4'd8) |-> next_pc == pc + 11'd1);

  a_r8_always_literal: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && insn[31:25] == 7'b1000_000 && insn[24:21] == 4'd0) |-> next_pc == insn[12:2]);

  a_r7_only_alu_writes: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (insn_valid && insn[31:28] == 4'd7));

endmodule

bind cp_exec cp_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn), .pc(pc),
  .next_pc(next_pc), .wb_en(wb_en), .wb_data(wb_data),
  .zero_flag(zero_flag), .ovf_flag(ovf_flag)
);

// File: tb/cp_exec_bench.sv
module cp_exec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [10:0] pc = '0;
  logic [10:0] next_pc;
  logic        wb_en;
  logic [1:0]  wb_sel;
  logic [15:0] wb_data;
  logic        zero_flag, ovf_flag;

  cp_exec u_cp_exec (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] m_r [4];
  logic m_z, m_o;

  logic [15:0] vals [12] = '{16'h0000, 16'h0001, 16'h0002, 16'h7fff, 16'h8000, 16'hffff,
                             16'h1234, 16'habcd, 16'h000f, 16'h0010, 16'h00ff, 16'hfffe};

  function automatic logic [31:0] alu_r(input logic [3:0] s, input logic [1:0] d, a, b);
    return {4'd7, 3'd0, s, 15'd0, b, a, d};
  endfunction
  function automatic logic [31:0] alu_i(input logic [3:0] s, input logic [1:0] d, a, input logic [15:0] k);
    return {4'd7, 3'd1, s, 1'b0, k, a, d};
  endfunction
  function automatic logic [31:0] bx(input logic [2:0] c, input logic rg, input logic [10:0] ad, input logic [1:0] t);
    return {4'd8, 3'd0, c, rg, 8'd0, ad, t};
  endfunction
  function automatic logic [31:0] brel(input logic sg, input logic [6:0] mg, input logic cm, input logic [15:0] k);
    return {4'd8, 3'd1, sg, mg, cm, k};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic [10:0] p, input logic v, input string req);
    logic e_we; logic [15:0] e_d, a, b; logic e_o; logic [10:0] e_np, t; logic tk;
    @(negedge clk);
    insn = w; pc = p; insn_valid = v;
    #1;
    e_we = 0; e_d = '0; e_o = 0; tk = 0; t = '0;
    a = m_r[w[3:2]];
    b = (w[27:25] == 3'd1) ? w[19:4] : m_r[w[5:4]];
    if (v && w[31:28] == 4'd7 && w[27:25] <= 3'd1 && w[24:21] <= 4'd6) begin
      e_we = 1;
      case (w[24:21])
        4'd0: {e_o, e_d} = 17'(a) + 17'(b);
        4'd1: begin e_d = a - b; e_o = a < b; end
        4'd2: e_d = a & b;
        4'd3: e_d = a | b;
        4'd4: e_d = b;
        4'd5: e_d = 16'(32'(a) << b);
        default: e_d = 16'(32'(a) >> b);
      endcase
    end
    if (v && w[31:28] == 4'd8 && w[27:25] == 3'd0) begin
      t = w[21] ? m_r[w[1:0]][10:0] : w[12:2];
      tk = (w[24:22] == 0) || (w[24:22] == 1 && m_z) || (w[24:22] == 2 && m_o);
    end else if (v && w[31:28] == 4'd8 && w[27:25] == 3'd1) begin
      t = w[24] ? p - 11'(w[23:17]) : p + 11'(w[23:17]);
      tk = w[16] ? (m_r[0] >= w[15:0]) : (m_r[0] < w[15:0]);
    end
    e_np = !v ? p : (tk ? t : p + 11'd1);
    chk(zero_flag == m_z, {req, " zero flag"}, 32'(zero_flag), 32'(m_z));
    chk(ovf_flag == m_o, {req, " overflow flag"}, 32'(ovf_flag), 32'(m_o));
    chk(wb_en == e_we, {req, " wb_en"}, 32'(wb_en), 32'(e_we));
    if (e_we) begin
      chk(wb_sel == w[1:0], {req, " wb_sel"}, 32'(wb_sel), 32'(w[1:0]));
      chk(wb_data == e_d, {req, " wb_data"}, 32'(wb_data), 32'(e_d));
    end
    chk(next_pc == e_np, {req, " next_pc"}, 32'(next_pc), 32'(e_np));
    @(posedge clk);
    if (e_we) begin
      m_r[w[1:0]] = e_d; m_z = (e_d == 0); m_o = e_o;
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_r[i] = '0;
    m_z = 0; m_o = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state seen through moves and flag outputs
    for (int k = 0; k < 4; k++) run(alu_r(4'd4, 2'(k), 2'd0, 2'(k)), 11'd0, 1, "R1");
    // R2 R3 R4 R5 R6 R8: sweep every select over operand pairs, then flag branches
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++) begin
          run(alu_i(4'd4, 2'd1, 2'd0, vals[i]), 11'd10, 1, "R4");
          run(alu_i(4'd4, 2'd2, 2'd3, vals[j]), 11'd11, 1, "R4");
          run(alu_r(4'(s), 2'd3, 2'd1, 2'd2), 11'd12, 1, s == 7 ? "R7" : "R2");
          run(bx(3'd1, 1'b0, 11'(i * 100 + j), 2'd0), 11'd13, 1, "R5");
          run(bx(3'd2, 1'b0, 11'(j * 150 + 7), 2'd0), 11'd14, 1, "R6");
          run(alu_i(4'(s), 2'd0, 2'd1, vals[j]), 11'd15, 1, s == 7 ? "R7" : "R3");
          run(bx(3'd2, 1'b1, 11'd0, 2'd3), 11'd16, 1, "R8");
          run(bx(3'd1, 1'b1, 11'd0, 2'd1), 11'd17, 1, "R8");
        end
    run(alu_i(4'd15, 2'd0, 2'd0, 16'h0000), 11'd3, 1, "R7");
    run(alu_r(4'd0, 2'd1, 2'd1, 2'd1) | 32'h0400_0000, 11'd3, 1, "R7");
    for (int c = 0; c < 8; c++) run(bx(3'(c), 1'b0, 11'h555, 2'd0), 11'd2047, 1, "R8");
    for (int c = 0; c < 8; c++) run(bx(3'(c), 1'b1, 11'd0, 2'd2), 11'd100, 1, "R8");
    // R9: relative branches over R0 values, literals, directions and wrap
    for (int i = 0; i < 12; i++) begin
      run(alu_i(4'd4, 2'd0, 2'd0, vals[i]), 11'd0, 1, "R4");
      for (int j = 0; j < 12; j++)
        for (int m = 0; m < 4; m++) begin
          logic [10:0] p;
          p = (m == 0) ? 11'd0 : (m == 1) ? 11'd5 : (m == 2) ? 11'd2040 : 11'd2047;
          run(brel(1'b0, 7'(m == 3 ? 127 : m), 1'b0, vals[j]), p, 1, "R9");
          run(brel(1'b1, 7'(m == 0 ? 127 : m), 1'b1, vals[j]), p, 1, "R9");
        end
    end
    // R10: other major codes and sub-classes step sequentially, wrap at 2047
    for (int o = 0; o < 16; o++) if (o != 7 && o != 8) run({4'(o), 28'h0ff_ffff}, 11'(o * 131), 1, "R10");
    for (int sb = 2; sb < 8; sb++) run({4'd8, 3'(sb), 25'h1ff_ffff}, 11'd2047, 1, "R10");
    // R11: idle cycles change nothing
    run(alu_i(4'd4, 2'd2, 2'd0, 16'h4242), 11'd7, 1, "R4");
    run(alu_i(4'd4, 2'd2, 2'd0, 16'h0000), 11'd9, 0, "R11");
    run(alu_r(4'd1, 2'd2, 2'd2, 2'd3), 11'd9, 0, "R11");
    run(alu_r(4'd4, 2'd0, 2'd0, 2'd2), 11'd9, 1, "R11");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule